// File: doc/BRIEF.md
# L1 Memory Test Access Engine

This block lets software reach the on-chip L1 data memory indirectly, one 64-bit word at a time. It holds a small register file: a read-only base-address register, a command register and two 32-bit data registers. Software first loads the data registers if it wants a write. It then writes a command word. A nonzero command is checked for legality and decoded into a physical L1 address. The engine then performs a single 64-bit read or write through a request/ready memory port.

A read fills both data registers from the returned word. A write sends the two data registers out as one 64-bit word. Two commands are refused and flagged: a command that sets a reserved bit, and a command that asks for the tag array rather than the data array. The engine reports busy from the start of a transfer until the memory side acknowledges it. While it is busy, register writes are dropped.

Top module: `l1_test_access`

## Requirements
- R1: After reset the command and data registers read 0, `busy`, `errUndef`, `errTag` and `memReq` are 0, and the base register reads 0xFF800000.
- R2: Register select encoding is 0 = base, 1 = command, 2 = data low, 3 = data high. The base register always reads 0xFF800000 and ignores writes.
- R3: A nonzero, legal command written while idle raises `busy` and `memReq` on the next cycle. A zero command write only stores the value: it starts no transfer and leaves both error flags unchanged.
- R4: The memory address is the base value OR-ed with scattered command fields. Address bit 11 takes command bit 26, address bit 21 takes bit 24, address bit 15 takes bit 23, and address bits 13:12 take bits 17:16. Command bits 14 and 10:3 land on the same address bits.
- R5: A nonzero command with any bit of mask 0xFA7CB801 set sets `errUndef` and starts no transfer.
- R6: A nonzero command with bit 2 (data-array select) clear sets `errTag` and starts no transfer. Both flags may be set together. Every nonzero command write while idle replaces both flags with the result for that command.
- R7: `memReq`, `memAddr`, `memWe` and `memWdata` stay constant until a cycle in which `memReady` is high. In the following cycle `memReq` and `busy` are 0.
- R8: With command bit 1 set, the transfer is a write: `memWe` is 1 and `memWdata` is {data high, data low}.
- R9: With command bit 1 clear, the transfer is a read: at the acknowledge, `memRdata[31:0]` goes to data low and `memRdata[63:32]` goes to data high.
- R10: Writes to the command or data registers while `busy` is 1 are ignored. They start no second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regSel` |
| busy | output | 1 | Transfer in progress |
| errUndef | output | 1 | Last nonzero command set a reserved bit |
| errTag | output | 1 | Last nonzero command asked for the tag array |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 64 | Memory write data |
| memReady | input | 1 | Memory acknowledge |
| memRdata | input | 64 | Memory read data, valid with `memReady` |

## Verification
A wrong command or data register shows at once on `memAddr`, `memWe` or `memWdata` in the first cycle of the request. It also shows on `regRdata` at the next read-back. A stuck or early-cleared busy state shows within one cycle of the acknowledge, as a request that stays up or one that drops before `memReady`. A refused command that still starts shows as `memReq` rising one cycle after the write. Wrong error flag state is visible on the flag outputs right after each command write.

// File: rtl/l1ta_pkg.sv
package l1ta_pkg;
  // Register select codes
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_CMD   = 2'd1;
  localparam logic [1:0] SEL_DLOW  = 2'd2;
  localparam logic [1:0] SEL_DHIGH = 2'd3;

  // Command field positions
  localparam int CMD_WRITE_BIT = 1;
  localparam int CMD_DSEL_BIT  = 2;
  localparam int CMD_WAY_BIT   = 26;
  localparam int CMD_SIDE_BIT  = 24;
  localparam int CMD_BANK_BIT  = 23;
  localparam int CMD_SUB_LO    = 16;

  // Address bit positions the fields land on
  localparam int ADR_WAY_BIT   = 11;
  localparam int ADR_SIDE_BIT  = 21;
  localparam int ADR_BANK_BIT  = 15;
  localparam int ADR_SUB_LO    = 12;
  localparam int ADR_PASS_HI   = 14;

  typedef struct packed {
    logic loadCmd;
    logic loadDLow;
    logic loadDHigh;
    logic captureRd;
  } l1taStrobes_t;
endpackage

// File: rtl/l1ta_ctrl.sv
module l1ta_ctrl
  import l1ta_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] UNDEF_MASK = 32'hFA7CB801
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              memReady,
  input  logic              cmdIsWrite,
  output l1taStrobes_t      strobes,
  output logic              busy,
  output logic              errUndef,
  output logic              errTag
);
  logic idle;
  logic cmdWrite;
  logic cmdNonzero;
  logic hitsUndef;
  logic wantsTag;
  logic startXfer;
  logic ackSeen;

  assign idle       = !busy;
  assign cmdWrite   = regWe && (regSel == SEL_CMD) && idle;
  assign cmdNonzero = |regWdata;
  assign hitsUndef  = |(regWdata & UNDEF_MASK);
  assign wantsTag   = !regWdata[CMD_DSEL_BIT];
  assign startXfer  = cmdWrite && cmdNonzero && !hitsUndef && !wantsTag;
  assign ackSeen    = busy && memReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      errUndef <= 1'b0;
      errTag   <= 1'b0;
    end else begin
      if (cmdWrite && cmdNonzero) begin
        errUndef <= hitsUndef;
        errTag   <= wantsTag;
      end
      if (startXfer)
        busy <= 1'b1;
      else if (ackSeen)
        busy <= 1'b0;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.loadCmd   = cmdWrite;
    strobes.loadDLow  = regWe && (regSel == SEL_DLOW) && idle;
    strobes.loadDHigh = regWe && (regSel == SEL_DHIGH) && idle;
    strobes.captureRd = ackSeen && !cmdIsWrite;
  end
endmodule

// File: rtl/l1ta_datapath.sv
module l1ta_datapath
  import l1ta_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] BASE_RESET = 32'hFF800000
) (
  input  logic                clk,
  input  logic                rstN,
  input  l1taStrobes_t        strobes,
  input  logic [1:0]          regSel,
  input  logic [DATA_W-1:0]   regWdata,
  input  logic [2*DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0] memWdata,
  output logic                cmdIsWrite
);
  localparam int MEM_W = 2 * DATA_W;

  logic [DATA_W-1:0] cmdReg;
  logic [DATA_W-1:0] dLow;
  logic [DATA_W-1:0] dHigh;
  logic [DATA_W-1:0] baseReg;
  logic [DATA_W-1:0] scatter;

  assign baseReg = BASE_RESET;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      dLow   <= '0;
      dHigh  <= '0;
    end else begin
      if (strobes.loadCmd)   cmdReg <= regWdata;
      if (strobes.loadDLow)  dLow   <= regWdata;
      if (strobes.loadDHigh) dHigh  <= regWdata;
      if (strobes.captureRd) begin
        dLow  <= memRdata[DATA_W-1:0];
        dHigh <= memRdata[MEM_W-1:DATA_W];
      end
    end
  end

  always_comb begin
    scatter                            = '0;
    scatter[10:3]                      = cmdReg[10:3];
    scatter[ADR_PASS_HI]               = cmdReg[ADR_PASS_HI];
    scatter[ADR_SUB_LO+1:ADR_SUB_LO]   = cmdReg[CMD_SUB_LO+1:CMD_SUB_LO];
    scatter[ADR_WAY_BIT]               = cmdReg[CMD_WAY_BIT];
    scatter[ADR_BANK_BIT]              = cmdReg[CMD_BANK_BIT];
    scatter[ADR_SIDE_BIT]              = cmdReg[CMD_SIDE_BIT];
  end

  assign memAddr    = baseReg | scatter;
  assign memWdata   = {dHigh, dLow};
  assign cmdIsWrite = cmdReg[CMD_WRITE_BIT];

  always_comb begin
    case (regSel)
      SEL_BASE: regRdata = baseReg;
      SEL_CMD:  regRdata = cmdReg;
      SEL_DLOW: regRdata = dLow;
      default:  regRdata = dHigh;
    endcase
  end
endmodule

// File: rtl/l1_test_access.sv
module l1_test_access
  import l1ta_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] BASE_RESET = 32'hFF800000,
  parameter logic [DATA_W-1:0] UNDEF_MASK = 32'hFA7CB801
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regSel,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic                busy,
  output logic                errUndef,
  output logic                errTag,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [2*DATA_W-1:0] memWdata,
  input  logic                memReady,
  input  logic [2*DATA_W-1:0] memRdata
);
  l1taStrobes_t strobes;
  logic         cmdIsWrite;

  l1ta_ctrl #(.DATA_W(DATA_W), .UNDEF_MASK(UNDEF_MASK)) ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .memReady(memReady), .cmdIsWrite(cmdIsWrite),
    .strobes(strobes), .busy(busy), .errUndef(errUndef), .errTag(errTag)
  );

  l1ta_datapath #(.DATA_W(DATA_W), .BASE_RESET(BASE_RESET)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regSel(regSel),
    .regWdata(regWdata), .memRdata(memRdata), .regRdata(regRdata),
    .memAddr(memAddr), .memWdata(memWdata), .cmdIsWrite(cmdIsWrite)
  );

  assign memReq = busy;
  assign memWe  = cmdIsWrite;
endmodule

// File: rtl/l1ta_checker.sv
module l1ta_checker #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] BASE_RESET = 32'hFF800000,
  parameter logic [DATA_W-1:0] UNDEF_MASK = 32'hFA7CB801
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [1:0]          regSel,
  input logic [DATA_W-1:0]   regWdata,
  input logic [DATA_W-1:0]   regRdata,
  input logic                busy,
  input logic                memReq,
  input logic                memWe,
  input logic [DATA_W-1:0]   memAddr,
  input logic [2*DATA_W-1:0] memWdata,
  input logic                memReady
);
  logic cmdIdleWr;
  assign cmdIdleWr = regWe && (regSel == 2'd1) && !busy;

  p_base_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd0) |-> (regRdata == BASE_RESET));

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIdleWr && (regWdata != '0) && ((regWdata & UNDEF_MASK) == '0) && regWdata[2])
    |=> (memReq && busy));

  p_zero_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIdleWr && (regWdata == '0)) |=> !memReq);

  p_undef_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIdleWr && ((regWdata & UNDEF_MASK) != '0)) |=> !memReq);

  p_tag_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdIdleWr && !regWdata[2]) |=> !memReq);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> (!memReq && !busy));
endmodule

bind l1_test_access l1ta_checker #(
  .DATA_W(DATA_W), .BASE_RESET(BASE_RESET), .UNDEF_MASK(UNDEF_MASK)
) chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
  .regRdata(regRdata), .busy(busy), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady)
);

// File: tb/l1_test_access_test.sv
module l1_test_access_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busy, errUndef, errTag, memReq, memWe;
  logic [31:0] memAddr;
  logic [63:0] memWdata;
  logic        memReady = 1'b0;
  logic [63:0] memRdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  l1_test_access uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .busy(busy), .errUndef(errUndef), .errTag(errTag),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [31:0] cmd;
    logic        start;
    logic        isWr;
    logic        eU;
    logic        eT;
    logic [31:0] addr;
  } vec_t;

  // R4 R5 R6 R8 R9 vectors
  localparam vec_t VECS [7] = '{
    '{32'h0503_47FC, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFA0_7FF8},
    '{32'h0080_0016, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFF80_8010},
    '{32'h0000_0805, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0},
    '{32'h0000_0008, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0},
    '{32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0},
    '{32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0},
    '{32'h0000_0004, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFF80_0000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdata;
  endtask

  // Called at a negedge with the request already up
  task automatic serve(input string tag, input logic [31:0] expAddr, input logic expWe,
                       input logic [63:0] expWdata, input int lat, input logic [63:0] rdata);
    chk({tag, " R7 req"}, 64'(memReq), 64'd1);
    chk({tag, " R4 addr"}, 64'(memAddr), 64'(expAddr));
    chk({tag, " R8 we"}, 64'(memWe), 64'(expWe));
    if (expWe) chk({tag, " R8 wdata"}, memWdata, expWdata);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk({tag, " R7 held addr"}, 64'(memAddr), 64'(expAddr));
    end
    memReady = 1'b1; memRdata = rdata;
    @(negedge clk);
    memReady = 1'b0; memRdata = '0;
    chk({tag, " R7 released"}, {62'd0, memReq, busy}, 64'd0);
  endtask

  initial begin
    logic [31:0] rv;
    logic [31:0] lo, hi;
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 flags", {60'd0, busy, errUndef, errTag, memReq}, 64'd0);
    regRead(2'd0, rv); chk("R1 base", 64'(rv), 64'hFF80_0000);
    regRead(2'd1, rv); chk("R1 cmd", 64'(rv), 64'd0);
    regRead(2'd2, rv); chk("R1 dlow", 64'(rv), 64'd0);
    regRead(2'd3, rv); chk("R1 dhigh", 64'(rv), 64'd0);

    // R2 base ignores writes
    regWrite(2'd0, 32'h1234_5678);
    regRead(2'd0, rv); chk("R2 base after write", 64'(rv), 64'hFF80_0000);

    // Table walk
    for (int i = 0; i < 7; i++) begin
      lo = 32'h1000_0000 + i;
      hi = 32'h2000_0000 + i;
      rd = {32'hA5A5_0000 + 32'(i), 32'h5A5A_0000 + 32'(i)};
      regWrite(2'd2, lo);
      regWrite(2'd3, hi);
      regWrite(2'd1, VECS[i].cmd);
      chk($sformatf("R5 errUndef row %0d", i), 64'(errUndef), 64'(VECS[i].eU));
      chk($sformatf("R6 errTag row %0d", i), 64'(errTag), 64'(VECS[i].eT));
      chk($sformatf("R3 start row %0d", i), {62'd0, memReq, busy},
          VECS[i].start ? 64'd3 : 64'd0);
      if (VECS[i].start && memReq)
        serve($sformatf("row %0d", i), VECS[i].addr, VECS[i].isWr, {hi, lo}, i % 3, rd);
      regRead(2'd1, rv); chk($sformatf("R3 cmd readback row %0d", i), 64'(rv), 64'(VECS[i].cmd));
      regRead(2'd2, rv);
      chk($sformatf("R9 dlow row %0d", i), 64'(rv),
          (VECS[i].start && !VECS[i].isWr) ? 64'(rd[31:0]) : 64'(lo));
      regRead(2'd3, rv);
      chk($sformatf("R9 dhigh row %0d", i), 64'(rv),
          (VECS[i].start && !VECS[i].isWr) ? 64'(rd[63:32]) : 64'(hi));
    end

    // R10 writes while busy ignored
    regWrite(2'd2, 32'h1111_1111);
    regWrite(2'd3, 32'h2222_2222);
    regWrite(2'd1, 32'h0000_0006);
    chk("R10 busy up", 64'(busy), 64'd1);
    regWrite(2'd2, 32'hDEAD_BEEF);
    regWrite(2'd1, 32'h0080_0004);
    chk("R10 wdata unchanged", memWdata, 64'h2222_2222_1111_1111);
    serve("busy", 32'hFF80_0000, 1'b1, 64'h2222_2222_1111_1111, 1, 64'd0);
    @(negedge clk);
    chk("R10 no second transfer", 64'(memReq), 64'd0);
    regRead(2'd2, rv); chk("R10 dlow kept", 64'(rv), 64'h1111_1111);
    regRead(2'd1, rv); chk("R10 cmd kept", 64'(rv), 64'h0000_0006);

    // R9 zero-latency read with distinct halves
    regWrite(2'd1, 32'h0400_0004);
    serve("zero lat", 32'hFF80_0800, 1'b0, 64'd0, 0, 64'hCAFE_F00D_0BAD_BEEF);
    regRead(2'd2, rv); chk("R9 zero-lat low", 64'(rv), 64'h0BAD_BEEF);
    regRead(2'd3, rv); chk("R9 zero-lat high", 64'(rv), 64'hCAFE_F00D);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule